// File: doc/BRIEF.md
# Received Data Block Demultiplexer

This block sits behind isochronous packet reception and takes the quadlet stream of received data blocks apart. Each quadlet comes with a valid flag and a flag that marks the first quadlet of a data block. A configurable number of leading quadlets is thrown away. The next quadlets are audio samples, one per channel, with channel 0 first. When any MIDI ports are configured, one MIDI quadlet follows the audio quadlets. Each audio sample leaves the block with its channel index and a flag taken from a per-channel IEC60958 label mask.

Software sets a run word and a channel register. When the run word changes from zero to non-zero, the stream starts, as long as the channel register does not hold all ones, which is the value meaning "unused". At that moment the skip count, the audio channel count and the MIDI port count are captured. The label mask is not captured: it stays live, so it can be changed while the stream runs. A zero run word stops the stream. The block flags block-start markers that arrive too early and quadlets that go past the end of a block, and it counts the surplus quadlets.

Top module: `rx_block_demux`

## Requirements
- R1: `stream_active` rises one cycle after `run_req` goes from zero to non-zero, unless `iso_chan` is all ones at that edge. It falls one cycle after `run_req` is zero. While it is low, no audio or MIDI output is produced.
- R2: The skip count, the channel count and the MIDI port count are captured only on the start edge. Changing them while the stream runs has no effect until the next start.
- R3: The quadlet carrying `in_sob` has block index 0. Quadlets with an index below the captured `first_idx` produce no output.
- R4: The quadlets at indices `first_idx` through `first_idx`+N-1 each produce an `aud_valid` pulse one cycle later, with `aud_chan` equal to the index minus `first_idx`. N is the captured `num_audio`, limited to MAX_CH.
- R5: `in_data[7:0]` is the first byte on the wire, and it is the most significant byte. `aud_data` and `midi_data` are equal to {in[7:0], in[15:8], in[23:16], in[31:24]}.
- R6: If the captured `num_midi` is non-zero, the quadlet at index `first_idx`+N produces a `midi_valid` pulse one cycle later. If it is zero, no MIDI output appears.
- R7: `aud_iec` equals bit `aud_chan` of `iec_mask` as that bit stood on the input quadlet's edge. A change to the mask takes effect on the next quadlet.
- R8: A quadlet whose index is at or beyond the block length (skip + N + 1 if MIDI is on, otherwise skip + N) produces an `overrun` pulse one cycle later. It also increments `err_cnt`, which saturates at all ones.
- R9: An `in_sob` quadlet that arrives while a block is open, and before that block reached its length, produces a `short_blk` pulse one cycle later. That quadlet still starts a new block as index 0.
- R10: After a start, quadlets received before the first `in_sob` are dropped. They produce no output and no error.
- R11: During and right after reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_req | input | 32 | Global run word; non-zero runs the stream |
| iso_chan | input | 32 | Stream channel; all ones means unused |
| first_idx | input | SKIP_W | Count of leading quadlets to skip |
| num_audio | input | NA_W | Audio channels per block |
| num_midi | input | 4 | MIDI port count, 0 to 8 |
| iec_mask | input | MAX_CH | Live per-channel IEC60958 label mask |
| in_valid | input | 1 | Input quadlet valid |
| in_sob | input | 1 | Input quadlet is first of a block |
| in_data | input | 32 | Input quadlet, first wire byte in [7:0] |
| stream_active | output | 1 | Stream is running |
| aud_valid | output | 1 | Audio sample strobe |
| aud_chan | output | CH_W | Audio channel index |
| aud_data | output | 32 | Audio sample, host order |
| aud_iec | output | 1 | IEC60958 label flag for this sample |
| midi_valid | output | 1 | MIDI quadlet strobe |
| midi_data | output | 32 | MIDI quadlet, host order |
| short_blk | output | 1 | Early block-start pulse |
| overrun | output | 1 | Surplus quadlet pulse |
| err_cnt | output | ERR_W | Saturating surplus-quadlet count |

## Verification
The stream is exercised under several configurations. One has no skip and no MIDI. One has both skip and MIDI, with gaps between quadlets. One asks for more channels than MAX_CH, which shows whether the limit and the MIDI index are right. Blocks that are too long and blocks cut short show whether surplus quadlets and early markers are told apart. A long run of surplus quadlets reaches the saturation of the counter. The other patterns are these:
- configuration changes while running, which show whether the captured values are used instead of the live inputs;
- mask flips between quadlets, which show whether the label mask is live;
- traffic before the first marker, which separates quietly dropped quadlets from errors;
- a stop, and a start with the unused channel value, which show the gating.

// File: rtl/rbd_pkg.sv
package rbd_pkg;

  typedef int unsigned uint_t;

  // What a received quadlet turns out to be
  typedef enum logic [2:0] {
    QK_NONE,
    QK_SKIP,
    QK_AUDIO,
    QK_MIDI,
    QK_EXTRA
  } qkind_e;

  // Wire order to host order: the first received byte becomes the MSB
  function automatic logic [31:0] wire_to_host(input logic [31:0] q);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*(3-b) +: 8] = q[8*b +: 8];
    return r;
  endfunction

  function automatic uint_t block_len(input uint_t skip, input uint_t na, input logic mid);
    return skip + na + (mid ? 32'd1 : 32'd0);
  endfunction

  function automatic qkind_e classify(input uint_t idx, input uint_t skip,
                                      input uint_t na, input logic mid);
    if (idx < skip) return QK_SKIP;
    if (idx < skip + na) return QK_AUDIO;
    if (mid && idx == skip + na) return QK_MIDI;
    return QK_EXTRA;
  endfunction

endpackage

// File: rtl/rbd_ctrl.sv
module rbd_ctrl
  import rbd_pkg::*;
#(
  parameter int SKIP_W = 6,
  parameter int NA_W   = 8,
  parameter int MAX_CH = 16,
  localparam int NAQ_W = $clog2(MAX_CH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       run_req,
  input  logic [31:0]       iso_chan,
  input  logic [SKIP_W-1:0] first_idx,
  input  logic [NA_W-1:0]   num_audio,
  input  logic [3:0]        num_midi,
  output logic              act_q,
  output logic              clr,
  output logic [SKIP_W-1:0] skip_q,
  output logic [NAQ_W-1:0]  na_q,
  output logic              mid_q
);

  logic run_nz, run_nz_q, start_ev;

  assign run_nz   = |run_req;
  assign start_ev = run_nz && !run_nz_q;
  assign clr      = start_ev || !run_nz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_nz_q <= 1'b0;
      act_q    <= 1'b0;
      skip_q   <= '0;
      na_q     <= '0;
      mid_q    <= 1'b0;
    end else begin
      run_nz_q <= run_nz;
      if (!run_nz) begin
        act_q <= 1'b0;
      end else if (start_ev) begin
        act_q  <= (iso_chan != '1);
        skip_q <= first_idx;
        na_q   <= (uint_t'(num_audio) > uint_t'(MAX_CH)) ? NAQ_W'(MAX_CH) : NAQ_W'(num_audio);
        mid_q  <= |num_midi;
      end
    end
  end

  // R1
  unused_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev && iso_chan == '1) |=> !act_q);
  // R1
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_nz |=> !act_q);
  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_nz && run_nz_q) |=> ($stable(skip_q) && $stable(na_q) && $stable(mid_q)));

endmodule

// File: rtl/rbd_parser.sv
module rbd_parser
  import rbd_pkg::*;
#(
  parameter int SKIP_W = 6,
  parameter int MAX_CH = 16,
  localparam int CH_W  = $clog2(MAX_CH),
  localparam int NAQ_W = $clog2(MAX_CH + 1),
  localparam int POS_W = $clog2((1 << SKIP_W) + MAX_CH + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              act,
  input  logic              in_valid,
  input  logic              in_sob,
  input  logic [SKIP_W-1:0] skip,
  input  logic [NAQ_W-1:0]  na,
  input  logic              mid,
  output qkind_e            kind,
  output logic [CH_W-1:0]   chan,
  output logic              short_ev
);

  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic [POS_W-1:0] pos_q, idx;
  logic             in_blk_q, take, blk;

  always_comb begin
    take     = act && in_valid;
    blk      = in_sob || in_blk_q;
    idx      = in_sob ? '0 : pos_q;
    kind     = QK_NONE;
    chan     = '0;
    if (take && blk) begin
      kind = classify(uint_t'(idx), uint_t'(skip), uint_t'(na), mid);
      if (kind == QK_AUDIO) chan = CH_W'(idx - POS_W'(skip));
    end
    short_ev = take && in_sob && in_blk_q &&
               (uint_t'(pos_q) < block_len(uint_t'(skip), uint_t'(na), mid));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q    <= '0;
      in_blk_q <= 1'b0;
    end else if (clr) begin
      pos_q    <= '0;
      in_blk_q <= 1'b0;
    end else if (take && blk) begin
      in_blk_q <= 1'b1;
      pos_q    <= (idx == POS_MAX) ? idx : idx + 1'b1;
    end
  end

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (short_ev && !clr) |=> (in_blk_q && pos_q == POS_W'(1)));
  // R10
  idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_blk_q && !in_sob) |-> (kind == QK_NONE));

endmodule

// File: rtl/rbd_outq.sv
module rbd_outq
  import rbd_pkg::*;
#(
  parameter int MAX_CH = 16,
  parameter int ERR_W  = 8,
  localparam int CH_W  = $clog2(MAX_CH),
  localparam int NAQ_W = $clog2(MAX_CH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act,
  input  qkind_e            kind,
  input  logic [CH_W-1:0]   chan,
  input  logic              short_ev,
  input  logic [31:0]       in_data,
  input  logic [MAX_CH-1:0] iec_mask,
  input  logic [NAQ_W-1:0]  na,
  output logic              aud_valid,
  output logic [CH_W-1:0]   aud_chan,
  output logic [31:0]       aud_data,
  output logic              aud_iec,
  output logic              midi_valid,
  output logic [31:0]       midi_data,
  output logic              short_blk,
  output logic              overrun,
  output logic [ERR_W-1:0]  err_cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aud_valid  <= 1'b0;
      aud_chan   <= '0;
      aud_data   <= '0;
      aud_iec    <= 1'b0;
      midi_valid <= 1'b0;
      midi_data  <= '0;
      short_blk  <= 1'b0;
      overrun    <= 1'b0;
      err_cnt    <= '0;
    end else begin
      aud_valid  <= (kind == QK_AUDIO);
      midi_valid <= (kind == QK_MIDI);
      overrun    <= (kind == QK_EXTRA);
      short_blk  <= short_ev;
      if (kind == QK_AUDIO) begin
        aud_chan <= chan;
        aud_data <= wire_to_host(in_data);
        aud_iec  <= iec_mask[chan];
      end
      if (kind == QK_MIDI) midi_data <= wire_to_host(in_data);
      if (kind == QK_EXTRA && err_cnt != '1) err_cnt <= err_cnt + 1'b1;
    end
  end

  // R1
  idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !act |=> (!aud_valid && !midi_valid));
  // R8
  err_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && $past(err_cnt) != '1) |-> (err_cnt == $past(err_cnt) + 1'b1));
  // R4
  chan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aud_valid |-> (NAQ_W'(aud_chan) < na));
  // R6
  one_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({aud_valid, midi_valid, overrun}));

endmodule

// File: rtl/rx_block_demux.sv
module rx_block_demux
  import rbd_pkg::*;
#(
  parameter int SKIP_W = 6,
  parameter int NA_W   = 8,
  parameter int MAX_CH = 16,
  parameter int ERR_W  = 8,
  localparam int CH_W  = $clog2(MAX_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       run_req,
  input  logic [31:0]       iso_chan,
  input  logic [SKIP_W-1:0] first_idx,
  input  logic [NA_W-1:0]   num_audio,
  input  logic [3:0]        num_midi,
  input  logic [MAX_CH-1:0] iec_mask,
  input  logic              in_valid,
  input  logic              in_sob,
  input  logic [31:0]       in_data,
  output logic              stream_active,
  output logic              aud_valid,
  output logic [CH_W-1:0]   aud_chan,
  output logic [31:0]       aud_data,
  output logic              aud_iec,
  output logic              midi_valid,
  output logic [31:0]       midi_data,
  output logic              short_blk,
  output logic              overrun,
  output logic [ERR_W-1:0]  err_cnt
);

  localparam int NAQ_W = $clog2(MAX_CH + 1);

  logic              act_q, clr, mid_q, short_ev;
  logic [SKIP_W-1:0] skip_q;
  logic [NAQ_W-1:0]  na_q;
  logic [CH_W-1:0]   chan;
  qkind_e            kind;

  rbd_ctrl #(.SKIP_W(SKIP_W), .NA_W(NA_W), .MAX_CH(MAX_CH)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .run_req(run_req), .iso_chan(iso_chan),
    .first_idx(first_idx), .num_audio(num_audio), .num_midi(num_midi),
    .act_q(act_q), .clr(clr), .skip_q(skip_q), .na_q(na_q), .mid_q(mid_q)
  );

  rbd_parser #(.SKIP_W(SKIP_W), .MAX_CH(MAX_CH)) i_parser (
    .clk(clk), .rst_n(rst_n), .clr(clr), .act(act_q), .in_valid(in_valid),
    .in_sob(in_sob), .skip(skip_q), .na(na_q), .mid(mid_q),
    .kind(kind), .chan(chan), .short_ev(short_ev)
  );

  rbd_outq #(.MAX_CH(MAX_CH), .ERR_W(ERR_W)) i_outq (
    .clk(clk), .rst_n(rst_n), .act(act_q), .kind(kind), .chan(chan),
    .short_ev(short_ev), .in_data(in_data), .iec_mask(iec_mask), .na(na_q),
    .aud_valid(aud_valid), .aud_chan(aud_chan), .aud_data(aud_data),
    .aud_iec(aud_iec), .midi_valid(midi_valid), .midi_data(midi_data),
    .short_blk(short_blk), .overrun(overrun), .err_cnt(err_cnt)
  );

  assign stream_active = act_q;

endmodule

// File: tb/test_rx_block_demux.sv
module test_rx_block_demux;
  localparam int CLK_PERIOD = 10;
  localparam int MAXC = 16;

  logic clk = 0, rst_n = 0;
  logic [31:0] run_req = 0, iso_chan = 0, in_data = 0;
  logic [5:0]  first_idx = 0;
  logic [7:0]  num_audio = 0;
  logic [3:0]  num_midi = 0;
  logic [15:0] iec_mask = 0;
  logic in_valid = 0, in_sob = 0;
  logic stream_active, aud_valid, aud_iec, midi_valid, short_blk, overrun;
  logic [3:0] aud_chan;
  logic [31:0] aud_data, midi_data;
  logic [7:0] err_cnt;

  rx_block_demux i_rx_block_demux (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string what, input logic [63:0] a, input logic [63:0] e);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", what, a, e);
    end
  endtask

  function automatic logic [31:0] swap_ref(input logic [31:0] d);
    logic [31:0] r = 0;
    for (int k = 0; k < 4; k++) r |= ((d >> (8*k)) & 32'hff) << (8*(3-k));
    return r;
  endfunction

  // Behavioural reference model, advanced on every rising edge
  int m_skip = 0, m_na = 0, m_pos = 0, e_cnt = 0, e_ch = 0;
  bit m_act = 0, m_mid = 0, m_inblk = 0, m_prev = 0;
  bit e_act = 0, e_av = 0, e_iec = 0, e_mv = 0, e_sh = 0, e_ov = 0;
  logic [31:0] e_ad = 0, e_md = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_inblk = 0; m_pos = 0; m_prev = 0; e_cnt = 0;
      e_act = 0; e_av = 0; e_mv = 0; e_sh = 0; e_ov = 0;
    end else begin
      int idx, total;
      e_av = 0; e_mv = 0; e_sh = 0; e_ov = 0;
      total = m_skip + m_na + (m_mid ? 1 : 0);
      if (m_act && in_valid) begin
        if (in_sob) begin
          if (m_inblk && m_pos < total) e_sh = 1;
          m_inblk = 1;
          idx = 0;
        end else idx = m_pos;
        if (m_inblk) begin
          if (idx < m_skip) ;
          else if (idx < m_skip + m_na) begin
            e_av = 1; e_ch = idx - m_skip; e_ad = swap_ref(in_data); e_iec = iec_mask[e_ch];
          end else if (m_mid && idx == m_skip + m_na) begin
            e_mv = 1; e_md = swap_ref(in_data);
          end else begin
            e_ov = 1;
            if (e_cnt < 255) e_cnt++;
          end
          m_pos = (idx >= 127) ? 127 : idx + 1;
        end
      end
      if (run_req == 0) begin
        m_act = 0; m_inblk = 0; m_pos = 0;
      end else if (!m_prev) begin
        m_act = (iso_chan != 32'hffff_ffff);
        m_skip = first_idx;
        m_na = (num_audio > MAXC) ? MAXC : num_audio;
        m_mid = (num_midi != 0);
        m_inblk = 0; m_pos = 0;
      end
      m_prev = (run_req != 0);
      e_act = m_act;
    end
  end

  // Per-cycle comparison, away from the rising edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(stream_active === e_act, "R1 stream_active", 64'(stream_active), 64'(e_act));
      chk(aud_valid === e_av, "R4 aud_valid", 64'(aud_valid), 64'(e_av));
      if (e_av) begin
        chk(aud_chan === 4'(e_ch), "R4 aud_chan", 64'(aud_chan), 64'(e_ch));
        chk(aud_data === e_ad, "R5 aud_data", 64'(aud_data), 64'(e_ad));
        chk(aud_iec === e_iec, "R7 aud_iec", 64'(aud_iec), 64'(e_iec));
      end
      chk(midi_valid === e_mv, "R6 midi_valid", 64'(midi_valid), 64'(e_mv));
      if (e_mv) chk(midi_data === e_md, "R5 midi_data", 64'(midi_data), 64'(e_md));
      chk(short_blk === e_sh, "R9 short_blk", 64'(short_blk), 64'(e_sh));
      chk(overrun === e_ov, "R8 overrun", 64'(overrun), 64'(e_ov));
      chk(err_cnt === 8'(e_cnt), "R8 err_cnt", 64'(err_cnt), 64'(e_cnt));
    end
  end

  task automatic put(input bit sob, input logic [31:0] d);
    @(negedge clk); in_valid = 1; in_sob = sob; in_data = d;
  endtask

  task automatic gap(input int n);
    repeat (n) begin @(negedge clk); in_valid = 0; in_sob = 0; end
  endtask

  task automatic blk(input int len, input int tagv, input bit gaps);
    for (int i = 0; i < len; i++) begin
      put(i == 0, {8'(tagv), 8'(i), 8'h5a ^ 8'(i), 8'hc3});
      if (gaps && i % 2 == 1) gap(1);
    end
  endtask

  task automatic launch(input logic [31:0] iso, input int sk, input int na, input int nm);
    @(negedge clk); run_req = 0; in_valid = 0; in_sob = 0;
    @(negedge clk);
    iso_chan = iso; first_idx = 6'(sk); num_audio = 8'(na); num_midi = 4'(nm);
    run_req = 32'h4;
    gap(1);
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state at the ports
    chk({stream_active, aud_valid, midi_valid, short_blk, overrun} === 5'b0,
        "R11 flags in reset", 64'({stream_active, aud_valid, midi_valid, short_blk, overrun}), 0);
    chk(err_cnt === 0 && aud_data === 0 && midi_data === 0, "R11 data in reset", 64'(err_cnt), 0);
    rst_n = 1;
    gap(1);
    chk(stream_active === 0 && err_cnt === 0, "R11 after reset", 64'(stream_active), 0);

    // Plain audio, no skip, no MIDI (R3 R4)
    iec_mask = 16'ha5c3;
    launch(32'd5, 0, 4, 0);
    blk(4, 1, 0); blk(4, 2, 1); gap(2);

    // Skip and MIDI with leading junk before the first marker (R3 R6 R10)
    launch(32'd7, 2, 3, 2);
    put(0, 32'hdead_0001); put(0, 32'hdead_0002); gap(1);
    blk(6, 3, 1); blk(6, 4, 0); gap(2);

    // Surplus quadlets (R8), then an early marker (R9)
    blk(9, 5, 0);
    blk(3, 6, 0); blk(6, 7, 0); gap(2);

    // Live config changes have no effect until restart (R2)
    first_idx = 0; num_audio = 1; num_midi = 0;
    blk(6, 8, 0); gap(2);

    // Mask flips between quadlets (R7)
    put(1, 32'h1111_0000);
    for (int i = 1; i < 6; i++) begin
      iec_mask = ~iec_mask;
      put(0, 32'h1111_0000 + 32'(i));
    end
    gap(2);

    // Stop: traffic ignored (R1)
    @(negedge clk); run_req = 0;
    blk(6, 9, 0); gap(2);

    // Start with the unused channel value (R1)
    launch(32'hffff_ffff, 0, 2, 0);
    blk(4, 10, 0); gap(2);

    // Channel count above the limit, with skip and MIDI (R4 R6)
    iec_mask = 16'h0f0f;
    launch(32'd1, 1, 20, 1);
    blk(18, 11, 0); blk(19, 12, 1); gap(2);

    // Long surplus run to saturation of the counter (R8)
    launch(32'd2, 0, 1, 0);
    blk(300, 13, 0); gap(3);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule